// File: doc/BRIEF.md
# General-Purpose Pin Bank with Interrupt Sensing

This block is one bank of general-purpose pins. Its width is a parameter, and a chip instantiates it once for each bank, for example one of 16 pins and one of 32 pins. Each bank sits at its own address offset and has its own interrupt line. For every pin, software sets the following through a synchronous register port:

- the output value and the output direction;
- a pull-up control, which is active low;
- a pull-down control;
- three interrupt configuration bits: sense, both-edge and polarity.

The bank drives only pad-control signals (output enable, output value, pull-up enable, pull-down enable) and samples the pad inputs.

Every pad input passes through a two-flop synchronizer. A third flop holds the value of the previous cycle, so that edges can be found. For each pin, a raw interrupt flag latches detected edges, or follows the level condition in level mode. It does this whatever the enable holds. The masked status is the raw flag ANDed with the per-pin enable, and the bank interrupt is the OR of the masked bits. Software clears latched edge flags by writing ones to a clear register.

Top module: `gpio_bank`

## Requirements
- R1: A write to offset 0x04 sets the direction register. Bit value 1 makes the pin an output, so `pad_oe_o` equals that register. A write to offset 0x00 sets the output latch, and `pad_out_o` equals it. Both outputs change on the clock edge that takes the write.
- R2: The pull-up register at offset 0x08 is active low. `pad_pu_en_o[i]` is the inverse of bit i. The register resets to all ones, so all pull-ups are disabled after reset.
- R3: The pull-down register at offset 0x0C is active high. `pad_pd_en_o` equals it, and it resets to zero.
- R4: A read of offset 0x00 returns the output latch bit for pins whose direction bit is 1, and the synchronized pad input for pins whose direction bit is 0. A read returns its data on `bus_rdata_o` one clock after the cycle in which `bus_sel_i` is high and `bus_wr_i` is low. Reads of offset 0x28 return zero.
- R5: Sense bit 0 (offset 0x10) selects edge mode. In edge mode with both-edge bit 0 (offset 0x14), polarity bit 1 (offset 0x18) latches rising edges and polarity bit 0 latches falling edges into the raw flag.
- R6: In edge mode with the both-edge bit set to 1, both rising and falling transitions latch the raw flag, whatever the polarity bit holds.
- R7: Sense bit 1 selects level mode. In this mode the raw flag equals the synchronized input when polarity is 1, and its inverse when polarity is 0. A clear write has no lasting effect while the level is active.
- R8: The raw status at offset 0x20 records events whatever the enable register (offset 0x1C) holds. The masked status at offset 0x24 is the raw status ANDed with the enable register.
- R9: Writing to offset 0x28 clears the latched edge flags of the pins whose bits are written as 1. Pins written as 0 keep their flags.
- R10: `irq_o` is high exactly when at least one masked status bit is high.
- R11: In edge mode, if a detected event and a clear of the same pin fall on the same clock edge, the event wins and the raw flag is 1 afterwards.
- R12: After reset the following are all zero: direction, output latch, pull-down, sense, both-edge, polarity, enable and raw status. The interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte offset of the register |
| bus_wdata_i | input | NPINS | Write data, one bit per pin |
| bus_rdata_o | output | NPINS | Read data, valid one cycle after the read strobe |
| pad_in_i | input | NPINS | Asynchronous pad inputs |
| pad_oe_o | output | NPINS | Pad output enables |
| pad_out_o | output | NPINS | Pad output values |
| pad_pu_en_o | output | NPINS | Pull-up enables, active high at the pad |
| pad_pd_en_o | output | NPINS | Pull-down enables |
| irq_o | output | 1 | Bank interrupt |

## Verification
The two functions that can meet in one cycle are a software clear and a freshly detected edge on the same pin. The flag must stay set, because otherwise the edge would be lost. The bench changes one pad a fixed number of cycles before a clear write, so that the event reaches the raw flag on exactly the edge that takes the write. The same write also clears a second pin that has no event. The bench expects the first flag to read 1 and the second to read 0. A sweep over all eight combinations of sense, both-edge and polarity also drives every pin transition (0→0, 1→0, 0→1, 1→1) at once, and compares the raw status, the masked status and the interrupt line with values computed in the bench.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] OFS_DATA   = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_PULLUP = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_PULLDN = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_SENSE  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_BOTH   = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_POL    = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_IE     = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_RAW    = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_MASKED = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_CLR    = 6'h28;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int NPINS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pad_i,
  output logic [NPINS-1:0] cur_o,
  output logic [NPINS-1:0] prev_o
);
  logic [NPINS-1:0] meta_q, meta_d;
  logic [NPINS-1:0] cur_q, cur_d;
  logic [NPINS-1:0] prev_q, prev_d;

  always_comb begin
    meta_d = pad_i;
    cur_d  = meta_q;
    prev_d = cur_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      cur_q  <= cur_d;
      prev_q <= prev_d;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_bank_sense.sv
module gpio_bank_sense #(
  parameter int NPINS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] cur_i,
  input  logic [NPINS-1:0] prev_i,
  input  logic [NPINS-1:0] sense_i,
  input  logic [NPINS-1:0] both_i,
  input  logic [NPINS-1:0] pol_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] raw_o
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic rise, fall, evt, lvl;
    logic raw_q, raw_d;

    always_comb begin
      rise = cur_i[g] & ~prev_i[g];
      fall = ~cur_i[g] & prev_i[g];
      if (both_i[g]) evt = rise | fall;
      else           evt = pol_i[g] ? rise : fall;
      lvl = pol_i[g] ? cur_i[g] : ~cur_i[g];
      if (sense_i[g]) raw_d = lvl;
      else            raw_d = evt | (raw_q & ~clr_i[g]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) raw_q <= 1'b0;
      else         raw_q <= raw_d;
    end

    assign raw_o[g] = raw_q;

    AST_EDGE_CATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sense_i[g] && !both_i[g] && (pol_i[g] ? (cur_i[g] && !prev_i[g]) : (!cur_i[g] && prev_i[g])))
        |=> raw_o[g]); // R5
    AST_BOTH_EDGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sense_i[g] && both_i[g] && (cur_i[g] != prev_i[g])) |=> raw_o[g]); // R6
    AST_LEVEL_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sense_i[g] |=> (raw_o[g] == ($past(pol_i[g]) ? $past(cur_i[g]) : !$past(cur_i[g])))); // R7
    AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sense_i[g] && clr_i[g] && (cur_i[g] == prev_i[g])) |=> !raw_o[g]); // R9
    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sense_i[g] && clr_i[g] && both_i[g] && (cur_i[g] != prev_i[g])) |=> raw_o[g]); // R11
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  input  logic [NPINS-1:0]  pin_i,
  input  logic [NPINS-1:0]  raw_i,
  output logic [NPINS-1:0]  rdata_o,
  output logic [NPINS-1:0]  out_o,
  output logic [NPINS-1:0]  dir_o,
  output logic [NPINS-1:0]  pu_o,
  output logic [NPINS-1:0]  pd_o,
  output logic [NPINS-1:0]  sense_o,
  output logic [NPINS-1:0]  both_o,
  output logic [NPINS-1:0]  pol_o,
  output logic [NPINS-1:0]  ie_o,
  output logic [NPINS-1:0]  clr_o
);
  logic wr_hit, rd_hit;
  logic en_out, en_dir, en_pu, en_pd, en_sense, en_both, en_pol, en_ie;
  logic [NPINS-1:0] out_q, dir_q, pu_q, pd_q, sense_q, both_q, pol_q, ie_q, rdata_q;
  logic [NPINS-1:0] out_d, dir_d, pu_d, pd_d, sense_d, both_d, pol_d, ie_d, rdata_d;
  logic [NPINS-1:0] rd_mux;

  always_comb begin
    wr_hit   = sel_i & wr_i;
    rd_hit   = sel_i & ~wr_i;
    en_out   = wr_hit && (addr_i == OFS_DATA);
    en_dir   = wr_hit && (addr_i == OFS_DIR);
    en_pu    = wr_hit && (addr_i == OFS_PULLUP);
    en_pd    = wr_hit && (addr_i == OFS_PULLDN);
    en_sense = wr_hit && (addr_i == OFS_SENSE);
    en_both  = wr_hit && (addr_i == OFS_BOTH);
    en_pol   = wr_hit && (addr_i == OFS_POL);
    en_ie    = wr_hit && (addr_i == OFS_IE);
    clr_o    = (wr_hit && (addr_i == OFS_CLR)) ? wdata_i : '0;

    out_d   = en_out   ? wdata_i : out_q;
    dir_d   = en_dir   ? wdata_i : dir_q;
    pu_d    = en_pu    ? wdata_i : pu_q;
    pd_d    = en_pd    ? wdata_i : pd_q;
    sense_d = en_sense ? wdata_i : sense_q;
    both_d  = en_both  ? wdata_i : both_q;
    pol_d   = en_pol   ? wdata_i : pol_q;
    ie_d    = en_ie    ? wdata_i : ie_q;

    case (addr_i)
      OFS_DATA:   rd_mux = (out_q & dir_q) | (pin_i & ~dir_q);
      OFS_DIR:    rd_mux = dir_q;
      OFS_PULLUP: rd_mux = pu_q;
      OFS_PULLDN: rd_mux = pd_q;
      OFS_SENSE:  rd_mux = sense_q;
      OFS_BOTH:   rd_mux = both_q;
      OFS_POL:    rd_mux = pol_q;
      OFS_IE:     rd_mux = ie_q;
      OFS_RAW:    rd_mux = raw_i;
      OFS_MASKED: rd_mux = raw_i & ie_q;
      default:    rd_mux = '0;
    endcase
    rdata_d = rd_hit ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      dir_q   <= '0;
      pu_q    <= '1;
      pd_q    <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      ie_q    <= '0;
      rdata_q <= '0;
    end else begin
      out_q   <= out_d;
      dir_q   <= dir_d;
      pu_q    <= pu_d;
      pd_q    <= pd_d;
      sense_q <= sense_d;
      both_q  <= both_d;
      pol_q   <= pol_d;
      ie_q    <= ie_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;
  assign out_o   = out_q;
  assign dir_o   = dir_q;
  assign pu_o    = pu_q;
  assign pd_o    = pd_q;
  assign sense_o = sense_q;
  assign both_o  = both_q;
  assign pol_o   = pol_q;
  assign ie_o    = ie_q;

  AST_MASKED_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && addr_i == OFS_MASKED) |=> ((rdata_o & ~$past(ie_q)) == '0)); // R8
  AST_CLEAR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && addr_i == OFS_CLR) |=> (rdata_o == '0)); // R4
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NPINS-1:0]  bus_wdata_i,
  output logic [NPINS-1:0]  bus_rdata_o,
  input  logic [NPINS-1:0]  pad_in_i,
  output logic [NPINS-1:0]  pad_oe_o,
  output logic [NPINS-1:0]  pad_out_o,
  output logic [NPINS-1:0]  pad_pu_en_o,
  output logic [NPINS-1:0]  pad_pd_en_o,
  output logic              irq_o
);
  logic rst_meta_q, rst_sync_q;
  logic [NPINS-1:0] cur, prev, raw, clr;
  logic [NPINS-1:0] out_r, dir_r, pu_r, pd_r, sense_r, both_r, pol_r, ie_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  gpio_bank_sync #(.NPINS(NPINS)) i_sync (
    .clk_i (clk_i), .rst_ni (rst_sync_q), .pad_i (pad_in_i),
    .cur_o (cur), .prev_o (prev)
  );

  gpio_bank_regs #(.NPINS(NPINS)) i_regs (
    .clk_i (clk_i), .rst_ni (rst_sync_q), .sel_i (bus_sel_i), .wr_i (bus_wr_i),
    .addr_i (bus_addr_i), .wdata_i (bus_wdata_i), .pin_i (cur), .raw_i (raw),
    .rdata_o (bus_rdata_o), .out_o (out_r), .dir_o (dir_r), .pu_o (pu_r),
    .pd_o (pd_r), .sense_o (sense_r), .both_o (both_r), .pol_o (pol_r),
    .ie_o (ie_r), .clr_o (clr)
  );

  gpio_bank_sense #(.NPINS(NPINS)) i_sense (
    .clk_i (clk_i), .rst_ni (rst_sync_q), .cur_i (cur), .prev_i (prev),
    .sense_i (sense_r), .both_i (both_r), .pol_i (pol_r), .clr_i (clr),
    .raw_o (raw)
  );

  assign pad_oe_o    = dir_r;
  assign pad_out_o   = out_r;
  assign pad_pu_en_o = ~pu_r;
  assign pad_pd_en_o = pd_r;
  assign irq_o       = |(raw & ie_r);

  AST_OE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    (bus_sel_i && bus_wr_i && bus_addr_i == OFS_DIR) |=> (pad_oe_o == $past(bus_wdata_i))); // R1
  AST_PULLUP_LOW: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    (bus_sel_i && bus_wr_i && bus_addr_i == OFS_PULLUP) |=> (pad_pu_en_o == ~$past(bus_wdata_i))); // R2
  AST_PULLDN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    (bus_sel_i && bus_wr_i && bus_addr_i == OFS_PULLDN) |=> (pad_pd_en_o == $past(bus_wdata_i))); // R3
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    irq_o |-> (ie_r != '0)); // R10
endmodule

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, wr = 1'b0;
  logic [5:0] addr = '0;
  logic [N-1:0] wdata = '0, pad = '0;
  logic [N-1:0] rdata, oe, pout, pu_en, pd_en;
  logic irq;
  int total = 0, failed = 0;
  bit done = 0;
  logic [N-1:0] rv, exp_v;

  always #10 clk = ~clk;

  gpio_bank #(.NPINS(N)) i_gpio_bank (
    .clk_i (clk), .rst_ni (rst_n), .bus_sel_i (sel), .bus_wr_i (wr),
    .bus_addr_i (addr), .bus_wdata_i (wdata), .bus_rdata_o (rdata),
    .pad_in_i (pad), .pad_oe_o (oe), .pad_out_o (pout),
    .pad_pu_en_o (pu_en), .pad_pd_en_o (pd_en), .irq_o (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [5:0] a, input logic [N-1:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic brd(input logic [5:0] a, output logic [N-1:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    @(negedge clk); sel = 0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1; idle(4);
    // R12 reset state
    chk("R12 oe", oe, 0); chk("R12 out", pout, 0); chk("R12 irq", irq, 0);
    brd(6'h20, rv); chk("R12 raw", rv, 0);
    brd(6'h08, rv); chk("R2 pullup reset reg", rv, 4'hF);
    chk("R2 pullup pad reset", pu_en, 0); chk("R3 pulldown reset", pd_en, 0);
    // R1 direction and output
    bwr(6'h04, 4'b0011); bwr(6'h00, 4'b0110);
    chk("R1 oe", oe, 4'b0011); chk("R1 out", pout, 4'b0110);
    // R2, R3
    bwr(6'h08, 4'b0110); chk("R2 pullup active low", pu_en, 4'b1001);
    bwr(6'h0C, 4'b0011); chk("R3 pulldown", pd_en, 4'b0011);
    // R4 data read mixes latch and pads
    pad = 4'b1000; idle(4);
    brd(6'h00, rv); chk("R4 data read", rv, (4'b0110 & 4'b0011) | (4'b1000 & ~4'b0011));
    brd(6'h28, rv); chk("R4 clear reads zero", rv, 0);
    bwr(6'h04, 4'b0000);
    // R5 R6 R7 R8 R10 sweep of all configuration codes, all four transitions
    for (int c = 0; c < 8; c++) begin
      bwr(6'h10, {N{c[2]}}); bwr(6'h14, {N{c[1]}}); bwr(6'h18, {N{c[0]}});
      bwr(6'h1C, 4'b0000);
      pad = 4'b1010; idle(6);
      bwr(6'h28, 4'hF); idle(1);
      pad = 4'b1100; idle(6);
      for (int i = 0; i < N; i++) begin
        logic st, en;
        st = i[0]; en = i[1];
        if (c[2]) exp_v[i] = c[0] ? en : !en;
        else      exp_v[i] = (st != en) && (c[1] || (c[0] ? en : !en));
      end
      brd(6'h20, rv); chk($sformatf("R5 R6 R7 R8 raw code %0d", c), rv, exp_v);
      bwr(6'h1C, 4'b0101);
      brd(6'h24, rv); chk($sformatf("R8 masked code %0d", c), rv, exp_v & 4'b0101);
      chk($sformatf("R10 irq code %0d", c), irq, |(exp_v & 4'b0101));
    end
    // R9 selective clear
    bwr(6'h1C, 4'b0000);
    bwr(6'h10, 4'h0); bwr(6'h14, 4'hF); bwr(6'h18, 4'h0);
    pad = 4'b0011; idle(6);
    brd(6'h20, rv); chk("R6 all toggled", rv, 4'hF);
    bwr(6'h28, 4'b0101);
    brd(6'h20, rv); chk("R9 selective clear", rv, 4'b1010);
    // R11 event and clear on the same edge: pin1 event, pin3 none
    @(negedge clk); pad = pad ^ 4'b0010;
    @(negedge clk);
    bwr(6'h28, 4'b1010);
    brd(6'h20, rv); chk("R11 event beats clear", rv, 4'b0010);
    chk("R8 R10 irq low with no enable", irq, 0);
    // R7 level mode: clear has no lasting effect
    bwr(6'h10, 4'hF); bwr(6'h18, 4'hF); idle(2);
    brd(6'h20, rv); chk("R7 level follows", rv, pad);
    bwr(6'h28, 4'hF);
    brd(6'h20, rv); chk("R7 clear no lasting effect", rv, pad);
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule